// File: doc/BRIEF.md
# Instruction Map Translator

This block turns a logical byte offset in instruction space into a 32-bit physical address. The offset range is split into equal mapping blocks of 128 KB, and there is one 16-bit map register per block. The block index picks a register. Bits 13:12 of that register choose the target space. Bits 6:0 hold a segment number. The block also shortens the requested byte count so that the access stays inside its mapping block. In the test space, the count is also kept inside a 2 KB window. An offset beyond the last block faults, and so does the reserved space code.

A request is given as an offset, a byte count and a valid strobe. Exactly one cycle later the registered result appears with a one-cycle valid pulse. The map registers are written and read through a small register port at addresses 0xff00 (block 0) and 0xff02 (block 1). Their reset contents depend on a boot-mode strap that is sampled while reset is held.

Top module: `imap_translator`

## Requirements
- R1: While reset is held with `hard_boot` low, both map registers load 0x1000. Block 0 and block 1 then map to on-chip instruction memory, and `rsp_valid` is low after reset.
- R2: While reset is held with `hard_boot` high, map register 0 loads 0x0000 and map register 1 loads 0x007f.
- R3: A write with `cfg_wr` high to address 0xff00 or 0xff02 stores the full 16-bit `cfg_wdata` into map register 0 or 1. `cfg_rdata` shows the addressed register without delay. For any other address, `cfg_rdata` is 0 and a write changes neither register.
- R4: An offset at or above 0x40000 (two blocks) gives `rsp_fault`=1, `rsp_addr`=0 and `rsp_len`=0.
- R5: Space code 00 (unified) gives the address {8'h00, segment[6:0], offset[16:0]}. Map bits 15:14 and 11:7 are ignored.
- R6: Space code 01 (on-chip) gives the address 0x01000000 + 0x20000 × block index + in-block offset. The segment field is ignored.
- R7: Space code 10 is reserved. It gives `rsp_fault`=1 with `rsp_addr`=0 and `rsp_len`=0.
- R8: Space code 11 (test window) gives the address 0x01000000 + (in-block offset mod 0x800). The length is cut so that the access ends at or before the 0x800 window edge.
- R9: For any access that does not fault, `rsp_len` = min(requested length, 0x20000 − in-block offset), and R8 may shorten it further. A requested length of 0 returns 0.
- R10: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R11: A request made in the same cycle as a map register write is translated with the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_boot | input | 1 | Boot-mode strap sampled during reset (selects the legacy map values) |
| req_valid | input | 1 | Translation request strobe |
| req_off | input | 24 | Logical instruction-space byte offset |
| req_len | input | 18 | Requested byte count |
| cfg_wr | input | 1 | Map register write enable |
| cfg_addr | input | 16 | Register port address (0xff00, 0xff02) |
| cfg_wdata | input | 16 | Map register write data |
| cfg_rdata | output | 16 | Read data of the addressed map register, 0 if none |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_fault | output | 1 | Translation fault |
| rsp_addr | output | 32 | Physical address |
| rsp_len | output | 18 | Permitted byte count |

## Verification
Directed cases set each space code in turn and use offsets in both blocks. This shows whether the block index is taken from the right bit and whether the segment field is used only by the unified space. Accesses placed just before the block end and just before a 2 KB test-window edge separate the two clip rules from each other. Out-of-range offsets and the reserved code confirm that a fault also clears the address and the length. Random requests with occasional random map writes then compare every result against a bench model. Some writes share a cycle with a request, which exposes any forwarding of a new map value into the current translation.

// File: rtl/iamap_pkg.sv
package iamap_pkg;

    localparam int          MAP_W      = 16;
    localparam int          SPACE_LSB  = 12;
    localparam int          SEG_W      = 7;
    localparam int          PA_W       = 32;
    localparam int          BASE_W     = 8;
    localparam logic [7:0]  BASE_UNI   = 8'h00;
    localparam logic [7:0]  BASE_INS   = 8'h01;
    localparam logic [15:0] MAP_ADDR0  = 16'hff00;
    localparam logic [15:0] DEF_MAP    = 16'h1000;

    typedef enum logic [1:0] {
        SP_UNIFIED = 2'b00,
        SP_ONCHIP  = 2'b01,
        SP_RSVD    = 2'b10,
        SP_TEST    = 2'b11
    } space_e;

    typedef struct packed {
        logic            fault;
        logic [PA_W-1:0] addr;
    } xlat_t;

    function automatic logic [MAP_W-1:0] legacy_map(input int idx);
        return (idx == 0) ? 16'h0000 : 16'h007f;
    endfunction

    function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [PA_W-1:0] base_of(input logic [7:0] b);
        return PA_W'(b) << (PA_W - BASE_W);
    endfunction

endpackage

// File: rtl/iamap_regs.sv
module iamap_regs
    import iamap_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hard_boot,
    input  logic                       wr,
    input  logic [15:0]                addr,
    input  logic [MAP_W-1:0]           wdata,
    output logic [MAP_W-1:0]           rdata,
    output logic [NREG-1:0][MAP_W-1:0] maps
);

    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_map
        localparam logic [15:0] MY_ADDR = 16'(32'(MAP_ADDR0) + 2 * g);

        assign hit[g] = (addr == MY_ADDR);

        always_ff @(posedge clk) begin
            if (rst) begin
                maps[g] <= hard_boot ? legacy_map(g) : DEF_MAP;
            end else if (wr && hit[g]) begin
                maps[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) rdata = maps[i];
        end
    end

endmodule

// File: rtl/iamap_xlate.sv
module iamap_xlate
    import iamap_pkg::*;
#(
    parameter int OFF_W   = 24,
    parameter int LEN_W   = 18,
    parameter int BLK_LG  = 17,
    parameter int NREG    = 2,
    parameter int TEST_LG = 11
) (
    input  logic [OFF_W-1:0]           off,
    input  logic [LEN_W-1:0]           len,
    input  logic [NREG-1:0][MAP_W-1:0] maps,
    output xlat_t                      res,
    output logic [LEN_W-1:0]           len_out
);

    localparam int           IDX_W      = (NREG > 1) ? $clog2(NREG) : 1;
    localparam longint       LIMIT      = longint'(NREG) << BLK_LG;
    localparam logic [31:0]  BLK_BYTES  = 32'd1 << BLK_LG;
    localparam logic [31:0]  TEST_BYTES = 32'd1 << TEST_LG;

    logic [BLK_LG-1:0] inblk;
    logic [IDX_W-1:0]  idx;
    logic              oor;
    logic [MAP_W-1:0]  sel;
    space_e            sp;
    logic [SEG_W-1:0]  seg;
    logic [31:0]       room_blk, room_test, clip_blk, clip_test;
    logic              unused_ok;

    assign inblk = off[BLK_LG-1:0];
    assign idx   = off[BLK_LG +: IDX_W];
    assign oor   = 64'(off) >= LIMIT;
    assign sel   = oor ? '0 : maps[idx];
    assign sp    = space_e'(sel[SPACE_LSB +: 2]);
    assign seg   = sel[SEG_W-1:0];

    assign unused_ok = &{1'b0, sel[MAP_W-1:SPACE_LSB+2], sel[SPACE_LSB-1:SEG_W]};

    assign room_blk  = BLK_BYTES - 32'(inblk);
    assign room_test = TEST_BYTES - 32'(inblk[TEST_LG-1:0]);
    assign clip_blk  = umin(32'(len), room_blk);
    assign clip_test = umin(clip_blk, room_test);

    always_comb begin
        res.fault = 1'b0;
        res.addr  = '0;
        len_out   = '0;
        if (oor) begin
            res.fault = 1'b1;
        end else begin
            unique case (sp)
                SP_UNIFIED: begin
                    res.addr = base_of(BASE_UNI) + (PA_W'(seg) << BLK_LG) + PA_W'(inblk);
                    len_out  = LEN_W'(clip_blk);
                end
                SP_ONCHIP: begin
                    res.addr = base_of(BASE_INS) + (PA_W'(idx) << BLK_LG) + PA_W'(inblk);
                    len_out  = LEN_W'(clip_blk);
                end
                SP_TEST: begin
                    res.addr = base_of(BASE_INS) + PA_W'(inblk[TEST_LG-1:0]);
                    len_out  = LEN_W'(clip_test);
                end
                default: begin
                    res.fault = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/imap_translator.sv
module imap_translator
    import iamap_pkg::*;
#(
    parameter int OFF_W   = 24,
    parameter int LEN_W   = 18,
    parameter int BLK_LG  = 17,
    parameter int NREG    = 2,
    parameter int TEST_LG = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_boot,
    input  logic              req_valid,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_addr,
    output logic [LEN_W-1:0]  rsp_len
);

    logic [NREG-1:0][MAP_W-1:0] maps;
    xlat_t                      nxt;
    logic [LEN_W-1:0]           nxt_len;

    iamap_regs #(.NREG(NREG)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .hard_boot (hard_boot),
        .wr        (cfg_wr),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .maps      (maps)
    );

    iamap_xlate #(
        .OFF_W   (OFF_W),
        .LEN_W   (LEN_W),
        .BLK_LG  (BLK_LG),
        .NREG    (NREG),
        .TEST_LG (TEST_LG)
    ) i_xlate (
        .off     (req_off),
        .len     (req_len),
        .maps    (maps),
        .res     (nxt),
        .len_out (nxt_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_addr  <= '0;
            rsp_len   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= nxt.fault;
                rsp_addr  <= nxt.addr;
                rsp_len   <= nxt_len;
            end
        end
    end

endmodule

// File: rtl/imap_translator_chk.sv
module imap_translator_chk
    import iamap_pkg::*;
#(
    parameter int OFF_W   = 24,
    parameter int LEN_W   = 18,
    parameter int BLK_LG  = 17,
    parameter int NREG    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [OFF_W-1:0]  req_off,
    input logic [LEN_W-1:0]  req_len,
    input logic              cfg_wr,
    input logic [15:0]       cfg_addr,
    input logic [15:0]       cfg_wdata,
    input logic [15:0]       cfg_rdata,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_addr,
    input logic [LEN_W-1:0]  rsp_len
);

    localparam longint LIMIT = longint'(NREG) << BLK_LG;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                         // R10
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                       // R10
    AST_OOR_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && 64'(req_off) >= LIMIT) |=> rsp_fault);              // R4
    AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_len == '0 && rsp_addr == '0));  // R7
    AST_LEN_NOT_GROWN: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_len <= $past(req_len)));                       // R9
    AST_NO_BLOCK_CROSS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |->
        ((32'(rsp_addr[BLK_LG-1:0]) + 32'(rsp_len)) <= (32'd1 << BLK_LG))); // R9
    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == MAP_ADDR0) |=>
        (cfg_addr != MAP_ADDR0 || cfg_rdata == $past(cfg_wdata)));        // R3

endmodule

bind imap_translator imap_translator_chk #(
    .OFF_W  (OFF_W),
    .LEN_W  (LEN_W),
    .BLK_LG (BLK_LG),
    .NREG   (NREG)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_off   (req_off),
    .req_len   (req_len),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_addr  (rsp_addr),
    .rsp_len   (rsp_len)
);

// File: tb/test_imap_translator.sv
module test_imap_translator;

    localparam int CLK_PERIOD = 10;
    localparam int BLK        = 32'h20000;
    localparam int WIN        = 32'h800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hard_boot = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_off = '0;
    logic [17:0] req_len = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_addr;
    logic [17:0] rsp_len;

    int n_cmp = 0;
    int n_err = 0;
    bit finished = 0;
    logic [15:0] mr [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    imap_translator i_imap_translator (
        .clk       (clk),
        .rst       (rst),
        .hard_boot (hard_boot),
        .req_valid (req_valid),
        .req_off   (req_off),
        .req_len   (req_len),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_addr  (rsp_addr),
        .rsp_len   (rsp_len)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input int unsigned off, input int unsigned len,
                                  output bit f, output int unsigned a, output int unsigned l);
        int unsigned idx, inb, room, o;
        logic [15:0] m;
        f = 0; a = 0; l = 0;
        if (off >= 2 * BLK) begin
            f = 1;
            return;
        end
        idx  = off / BLK;
        inb  = off % BLK;
        m    = mr[idx];
        room = BLK - inb;
        l    = (len < room) ? len : room;
        case (m[13:12])
            2'd0: a = (int'(m[6:0]) * BLK) + inb;
            2'd1: a = 32'h0100_0000 + BLK * idx + inb;
            2'd2: begin f = 1; l = 0; end
            default: begin
                o = inb % WIN;
                a = 32'h0100_0000 + o;
                if (l > WIN - o) l = WIN - o;
            end
        endcase
    endfunction

    task automatic do_reset(input bit hb);
        @(negedge clk);
        rst = 1'b1;
        hard_boot = hb;
        req_valid = 1'b0;
        cfg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        if (hb) begin mr[0] = 16'h0000; mr[1] = 16'h007f; end
        else    begin mr[0] = 16'h1000; mr[1] = 16'h1000; end
    endtask

    task automatic cfg_write(input logic [15:0] addr, input logic [15:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (addr == 16'hff00) mr[0] = data;
        if (addr == 16'hff02) mr[1] = data;
    endtask

    task automatic rd_check(input string tag, input logic [15:0] addr, input logic [15:0] exp);
        @(negedge clk);
        cfg_addr = addr;
        #1;
        chk(tag, "cfg_rdata", cfg_rdata, exp);
    endtask

    task automatic do_req(input string tag, input int unsigned off, input int unsigned len);
        bit ef; int unsigned ea, el;
        model(off, len, ef, ea, el);
        @(negedge clk);
        req_valid = 1'b1; req_off = off[23:0]; req_len = len[17:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "rsp_valid", rsp_valid, 1);
        chk(tag, "rsp_fault", rsp_fault, ef);
        chk(tag, "rsp_addr",  rsp_addr,  ea);
        chk(tag, "rsp_len",   rsp_len,   el);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        bit ef; int unsigned ea, el;
        seed = $urandom(32'h1a2b3c);

        // R1: default reset values and idle output
        do_reset(1'b0);
        chk("R1", "rsp_valid after reset", rsp_valid, 0);
        rd_check("R1", 16'hff00, 16'h1000);
        rd_check("R1", 16'hff02, 16'h1000);

        // R6: on-chip mapping in both blocks
        do_req("R6", 32'h100, 16);
        do_req("R6", 32'h20010, 8);

        // R10: pulse lasts exactly one cycle
        @(negedge clk);
        chk("R10", "rsp_valid idle", rsp_valid, 0);

        // R9: clipping at block end, zero length
        do_req("R9", 32'h1FFF0, 32'h40);
        do_req("R9", 32'h3FFFF, 4);
        do_req("R9", 32'h50, 0);

        // R4: out of range
        do_req("R4", 32'h40000, 4);
        do_req("R4", 32'hFFFFFF, 100);

        // R5: unified, with ignored bits set
        cfg_write(16'hff00, 16'hc0a5);
        rd_check("R3", 16'hff00, 16'hc0a5);
        do_req("R5", 32'h123, 32);
        chk("R5", "direct addr", rsp_addr, 32'h004A0123);

        // R7: reserved space
        cfg_write(16'hff02, 16'h2000);
        do_req("R7", 32'h20000, 4);

        // R8: test window wrap and clip
        cfg_write(16'hff02, 16'h3055);
        do_req("R8", 32'h20FFE, 8);
        chk("R8", "direct len", rsp_len, 2);
        do_req("R8", 32'h21003, 16);

        // R3: unmapped address neither reads nor writes
        cfg_write(16'hff04, 16'hbeef);
        rd_check("R3", 16'hff04, 16'h0000);
        rd_check("R3", 16'hff00, 16'hc0a5);
        rd_check("R3", 16'hff02, 16'h3055);

        // R11: same-cycle write uses the old value
        cfg_write(16'hff00, 16'h1000);
        model(32'h10, 4, ef, ea, el);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 16'hff00; cfg_wdata = 16'h2000;
        req_valid = 1'b1; req_off = 24'h10; req_len = 18'd4;
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        mr[0] = 16'h2000;
        chk("R11", "rsp_fault", rsp_fault, ef);
        chk("R11", "rsp_addr", rsp_addr, ea);
        do_req("R11", 32'h10, 4);

        // R2: legacy reset values and their mapping
        do_reset(1'b1);
        rd_check("R2", 16'hff00, 16'h0000);
        rd_check("R2", 16'hff02, 16'h007f);
        do_req("R2", 32'h20004, 4);
        chk("R2", "direct addr", rsp_addr, 32'h00FE0004);
        do_reset(1'b0);

        // random mix
        for (int i = 0; i < 500; i++) begin
            int unsigned len;
            if ($urandom % 6 == 0) begin
                cfg_write(($urandom % 2) ? 16'hff02 : 16'hff00, 16'($urandom));
            end
            len = ($urandom % 4 == 0) ? ($urandom % 32'h40000) : ($urandom % 64);
            do_req("R9 random", $urandom % 32'h48000, len);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule